// File: doc/BRIEF.md
# Latched Four-Level Segment Rail Selector

This block sits behind the column shift register of a dot-matrix LCD segment driver. It holds one data bit for every display column. All columns are captured together when the load strobe falls. For each column it then produces a 2-bit code that tells the analog output switch which of four bias rails to drive onto that segment electrode.

The chosen rail depends on three things:
- the held bit, where 1 means the segment is lit and 0 means it is dark;
- the frame alternation input, which swaps between the two rail pairs so that the panel sees no DC;
- an active-low blanking input, which forces every column to the same rail.

The load strobe is sampled on the system clock. A small state machine finds its high-to-low transition and fires a single capture. The alternation and blanking inputs act on the codes combinationally. Only the column data is stored.

The state machine has three states:
- `LD_EMPTY`: nothing has been captured since reset.
- `LD_ARMED`: the strobe has been seen high.
- `LD_HELD`: a capture has been made and the strobe is low.

It has these transitions:
- EMPTY→ARMED and HELD→ARMED when the strobe is sampled high.
- ARMED→HELD when the strobe is sampled low. This transition is the capture.
- Every other case stays in the current state.

Top module: `seg_rail_selector`

## Requirements
- R1: An active-low asynchronous reset clears every held column bit to 0 at once, without waiting for a clock edge. With alternation 0 and blanking 1 after reset, every column code is 2'b01.
- R2: The held bits change only on the clock edge at which the load strobe is first sampled 0 after having been sampled 1. Changes on the column data while the strobe stays high or stays low have no effect on the outputs.
- R3: On a capture, column i takes `shift_data[i]`. All columns are updated on that same edge. The code for column i appears on `rail_sel[2i+1:2i]`.
- R4: With blanking 1 and alternation 0, a held 0 gives code 2'b01 (non-select rail V3) and a held 1 gives code 2'b00 (select rail V1).
- R5: With blanking 1 and alternation 1, a held 0 gives code 2'b10 (non-select rail V4) and a held 1 gives code 2'b11 (select rail VEE).
- R6: With blanking 0, every column gives code 2'b00 (rail V1), whatever the held data and alternation input are. The held data is kept and reappears when blanking returns to 1.
- R7: Alternation and blanking act on the codes combinationally, with no clock edge in between. Only the column data is registered.
- R8: A strobe that is high when reset is released is taken as armed, so its first fall captures. A strobe held low throughout never captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the strobe is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_data | input | COLS (80) | Column bits from the shift register; bit i belongs to column i |
| load_strb | input | 1 | Load strobe; its falling transition captures all columns |
| alt_phase | input | 1 | Frame alternation; selects between the V3/V1 and the V4/VEE rail pairs |
| blank_n | input | 1 | Active-low blanking; 0 forces every column to rail V1 |
| rail_sel | output | 2*COLS (160) | Per-column rail codes: 00=V1, 01=V3, 10=V4, 11=VEE |

## Verification
The assertions assume that `load_strb` and `shift_data` are synchronous to `clk`. They also assume the column data is valid at the edge where the strobe is first seen low, so that a capture is defined by the sampled strobe values alone. The stimulus changes every input only on the falling clock edge. It holds the strobe high and low for whole cycles, and it changes data both while the strobe is high and after the fall, to show that only the capture edge counts. Alternation and blanking are toggled between clock edges and the codes are checked before the next edge, which keeps the combinational path separate from the registered one.

// File: rtl/seg_rail_pkg.sv
package seg_rail_pkg;

    typedef enum logic [1:0] {
        RAIL_V1  = 2'b00,
        RAIL_V3  = 2'b01,
        RAIL_V4  = 2'b10,
        RAIL_VEE = 2'b11
    } rail_t;

    typedef enum logic [1:0] {
        LD_EMPTY = 2'b00,
        LD_ARMED = 2'b01,
        LD_HELD  = 2'b10
    } ld_state_t;

    function automatic rail_t pick_rail(input logic lit, input logic alt, input logic blank_n);
        rail_t r;
        if (!blank_n) begin
            r = RAIL_V1;
        end else begin
            unique case ({alt, lit})
                2'b00:   r = RAIL_V3;
                2'b01:   r = RAIL_V1;
                2'b10:   r = RAIL_V4;
                default: r = RAIL_VEE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/load_strobe_fsm.sv
module load_strobe_fsm
    import seg_rail_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_strb,
    output logic      capture,
    output ld_state_t state
);

    ld_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LD_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            LD_EMPTY: if (load_strb)  state_nx = LD_ARMED;
            LD_ARMED: if (!load_strb) state_nx = LD_HELD;
            LD_HELD:  if (load_strb)  state_nx = LD_ARMED;
            default:  state_nx = LD_EMPTY;
        endcase
    end

    // outputs: capture fires on the ARMED->HELD transition
    always_comb begin
        capture = 1'b0;
        unique case (state)
            LD_ARMED: capture = !load_strb;
            default:  capture = 1'b0;
        endcase
    end

endmodule

// File: rtl/column_latch.sv
module column_latch #(
    parameter int COLS = 80
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [COLS-1:0] d,
    output logic [COLS-1:0] q
);

    for (genvar i = 0; i < COLS; i++) begin : g_col
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (capture) begin
                q[i] <= d[i];
            end
        end
    end

endmodule

// File: rtl/rail_encoder.sv
module rail_encoder
    import seg_rail_pkg::*;
#(
    parameter int COLS = 80,
    localparam int OUT_W = 2 * COLS
) (
    input  logic [COLS-1:0]  lit,
    input  logic             alt_phase,
    input  logic             blank_n,
    output logic [OUT_W-1:0] codes
);

    for (genvar i = 0; i < COLS; i++) begin : g_enc
        rail_t r;
        always_comb begin
            r = pick_rail(lit[i], alt_phase, blank_n);
        end
        assign codes[2*i +: 2] = r;
    end

endmodule

// File: rtl/seg_rail_selector.sv
module seg_rail_selector
    import seg_rail_pkg::*;
#(
    parameter int COLS = 80,
    localparam int OUT_W = 2 * COLS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [COLS-1:0]  shift_data,
    input  logic             load_strb,
    input  logic             alt_phase,
    input  logic             blank_n,
    output logic [OUT_W-1:0] rail_sel
);

    logic            capture;
    ld_state_t       ld_state;
    logic [COLS-1:0] lat_q;

    load_strobe_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_strb (load_strb),
        .capture   (capture),
        .state     (ld_state)
    );

    column_latch #(.COLS(COLS)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .d       (shift_data),
        .q       (lat_q)
    );

    rail_encoder #(.COLS(COLS)) u_enc (
        .lit       (lat_q),
        .alt_phase (alt_phase),
        .blank_n   (blank_n),
        .codes     (rail_sel)
    );

endmodule

// File: rtl/seg_rail_selector_chk.sv
module seg_rail_selector_chk
    import seg_rail_pkg::*;
#(
    parameter int COLS = 80,
    localparam int OUT_W = 2 * COLS
) (
    input logic             clk,
    input logic             rst_n,
    input logic [COLS-1:0]  shift_data,
    input logic             load_strb,
    input logic             alt_phase,
    input logic             blank_n,
    input logic [OUT_W-1:0] rail_sel,
    input logic [COLS-1:0]  lat_q,
    input ld_state_t        ld_state
);

    // R2: without a sampled high-to-low strobe the held bits do not move
    p_hold_without_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strb || !$past(load_strb)) |=> $stable(lat_q));

    // R3: an armed state with the strobe low captures the whole data word
    p_capture_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_state == LD_ARMED && !load_strb) |=> (lat_q == $past(shift_data)));

    // R6: blanking forces every code to the V1 rail
    p_blank_all_v1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> (rail_sel == '0));

    // R8: the strobe being high always leads to the armed state
    p_high_arms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_strb |=> (ld_state == LD_ARMED));

    for (genvar i = 0; i < COLS; i++) begin : g_col_chk
        // R4: alternation low picks between V1 and V3
        p_rail_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (blank_n && !alt_phase) |-> (rail_sel[2*i +: 2] == (lat_q[i] ? 2'b00 : 2'b01)));
        // R5: alternation high picks between VEE and V4
        p_rail_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (blank_n && alt_phase) |-> (rail_sel[2*i +: 2] == (lat_q[i] ? 2'b11 : 2'b10)));
    end

endmodule

bind seg_rail_selector seg_rail_selector_chk #(.COLS(COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_data (shift_data),
    .load_strb  (load_strb),
    .alt_phase  (alt_phase),
    .blank_n    (blank_n),
    .rail_sel   (rail_sel),
    .lat_q      (lat_q),
    .ld_state   (ld_state)
);

// File: tb/seg_rail_selector_test.sv
module seg_rail_selector_test;

    localparam int COLS = 80;
    localparam int OUT_W = 2 * COLS;
    localparam time TCK = 20ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [COLS-1:0]  shift_data = '0;
    logic             load_strb = 1'b0;
    logic             alt_phase = 1'b0;
    logic             blank_n = 1'b1;
    logic [OUT_W-1:0] rail_sel;

    int checks = 0;
    int errors = 0;
    logic [COLS-1:0] model = '0;

    always #(TCK/2) clk = ~clk;

    seg_rail_selector #(.COLS(COLS)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_data (shift_data),
        .load_strb  (load_strb),
        .alt_phase  (alt_phase),
        .blank_n    (blank_n),
        .rail_sel   (rail_sel)
    );

    function automatic logic [1:0] exp_code(input logic b, input logic a, input logic bn);
        if (!bn)        return 2'b00;
        if (!a && !b)   return 2'b01;
        if (!a &&  b)   return 2'b00;
        if ( a && !b)   return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic [COLS-1:0] rnd_word();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[COLS-1:0];
    endfunction

    task automatic check_all(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < COLS; i++) begin
            if (rail_sel[2*i +: 2] !== exp_code(model[i], alt_phase, blank_n)) begin
                if (first < 0) first = i;
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s: column %0d actual=%b expected=%b (%0d columns wrong)",
                     req, first, rail_sel[2*first +: 2],
                     exp_code(model[first], alt_phase, blank_n), bad);
        end
    endtask

    // strobe high for one cycle, then low; capture at the edge that sees it low
    task automatic load_word(input logic [COLS-1:0] w);
        @(negedge clk);
        shift_data = w;
        load_strb  = 1'b1;
        @(negedge clk);
        load_strb  = 1'b0;
        @(negedge clk);
        model      = w;
        shift_data = rnd_word();   // data after the capture must not matter
    endtask

    task automatic sweep_modes(input string req);
        for (int m = 0; m < 4; m++) begin
            alt_phase = m[0];
            blank_n   = ~m[1];
            #1;
            check_all(req);
        end
        alt_phase = 1'b0;
        blank_n   = 1'b1;
        #1;
    endtask

    initial begin : watchdog
        #(TCK * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        logic [COLS-1:0] a;
        logic [COLS-1:0] b;
        void'($urandom(32'd24680));

        // R1: reset state
        #(TCK * 3);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_all("R1 reset");

        // R4/R5/R6: directed corner words
        load_word('1);
        sweep_modes("R4 R5 R6 all ones");
        load_word('0);
        sweep_modes("R4 R5 R6 all zeros");
        a = '0;
        for (int i = 0; i < COLS; i += 2) a[i] = 1'b1;
        load_word(a);
        sweep_modes("R3 alternating columns");
        a = '0;
        a[0] = 1'b1;
        a[COLS-1] = 1'b1;
        load_word(a);
        sweep_modes("R3 end columns");

        // R3 R4 R5: random words
        for (int k = 0; k < 20; k++) begin
            load_word(rnd_word());
            sweep_modes("R3 random word");
        end

        // R7: combinational response between clock edges
        @(negedge clk);
        #3 alt_phase = 1'b1;
        #1 check_all("R7 alternation mid-cycle");
        #1 blank_n = 1'b0;
        #1 check_all("R7 blank mid-cycle");
        #1 blank_n = 1'b1;
        #1 check_all("R6 R7 data kept after blank");
        alt_phase = 1'b0;

        // R2: data changes while strobe low are ignored
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            shift_data = rnd_word();
        end
        @(negedge clk);
        #1 check_all("R2 strobe held low");

        // R2: data changes while strobe high are ignored until the fall
        a = rnd_word();
        b = rnd_word();
        @(negedge clk);
        shift_data = a;
        load_strb  = 1'b1;
        @(negedge clk);
        shift_data = rnd_word();
        #1 check_all("R2 strobe high no capture");
        @(negedge clk);
        shift_data = b;
        load_strb  = 1'b0;
        @(negedge clk);
        model = b;
        shift_data = rnd_word();
        #1 check_all("R2 value at fall captured");

        // R1: asynchronous reset mid-cycle
        @(negedge clk);
        #4 rst_n = 1'b0;
        model = '0;
        #1 check_all("R1 async clear");

        // R8: strobe high during reset release arms; fall captures
        load_strb = 1'b1;
        a = rnd_word();
        shift_data = a;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        load_strb = 1'b0;
        @(negedge clk);
        model = a;
        #1 check_all("R8 armed at reset release");

        // R8: strobe low since reset never captures
        rst_n = 1'b0;
        model = '0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            shift_data = rnd_word();
        end
        #1 check_all("R8 no strobe no capture");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule